// File: doc/BRIEF.md
# Video Sync Source Selector

This block sits in the front end of a video digitizer and decides which horizontal and which vertical sync source drives the rest of the capture path. Two horizontal candidates arrive: a dedicated HSYNC line and an HSYNC recovered from sync-on-green. Two vertical candidates arrive: a dedicated VSYNC line and the VSYNC produced by an external composite sync separator. A small activity detector watches each of the four candidates and marks it present while edges keep arriving within a programmable number of pixel clocks.

A control byte either forces a source for each axis or leaves the choice to the activity detectors. The same byte sets the output polarity of each sync and picks where the coast signal comes from: either a dedicated coast pin or the VSYNC currently chosen. All outputs are registered on the pixel clock, so a change of selection or control never shows up as a pulse shorter than one clock.

Control byte layout: bit 0 vertical source select, bit 1 vertical override, bit 2 vertical keep-polarity, bit 3 horizontal source select, bit 4 horizontal override, bit 5 horizontal invert, bit 6 coast source, bit 7 unused.

Top module: `sync_source_select`

## Requirements
- R1: An edge on a sync input sets its bit of `present_o` (bit 0 direct HSYNC, bit 1 green HSYNC, bit 2 direct VSYNC, bit 3 separator VSYNC) no later than three clock edges after the input changes.
- R2: A present flag returns to 0 once its input has shown no edge for more than `idle_limit_i` clocks.
- R3: With `ctrl_i[4]` = 1, `ctrl_i[3]` chooses the HSYNC source: 0 the direct line, 1 the sync-on-green line.
- R4: With `ctrl_i[4]` = 0, a single present HSYNC source is used; when both are present `ctrl_i[3]` decides as in R3; when neither is present the direct line is used.
- R5: `ctrl_i[5]` = 0 passes the chosen HSYNC unchanged to `hsync_o`; 1 inverts it.
- R6: With `ctrl_i[1]` = 1, `ctrl_i[0]` chooses the VSYNC source: 0 the direct line, 1 the separator output.
- R7: With `ctrl_i[1]` = 0, the direct VSYNC is used when it is present or when neither is present; the separator output is used when only it is present.
- R8: `ctrl_i[2]` = 0 inverts the chosen VSYNC onto `vsync_o`; 1 passes it unchanged.
- R9: `ctrl_i[6]` = 0 drives `coast_o` from `coast_pin_i`; 1 drives it from the chosen VSYNC before the polarity stage.
- R10: All outputs are registered: they are 0 during reset and reflect a change of `ctrl_i` or `coast_pin_i` exactly one clock edge later.
- R11: `ctrl_i[7]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_direct_i | input | 1 | Dedicated HSYNC line |
| hs_green_i | input | 1 | HSYNC recovered from sync-on-green |
| vs_direct_i | input | 1 | Dedicated VSYNC line |
| vs_sep_i | input | 1 | VSYNC from the composite sync separator |
| coast_pin_i | input | 1 | Dedicated coast line |
| ctrl_i | input | 8 | Control byte |
| idle_limit_i | input | CNT_W | Clocks without an edge before a source counts as absent |
| hsync_o | output | 1 | Selected HSYNC with requested polarity |
| vsync_o | output | 1 | Selected VSYNC with requested polarity |
| coast_o | output | 1 | Coast signal |
| present_o | output | 4 | Activity flags of the four sync inputs |

## Verification
The bench builds the block with an 8-bit idle counter, which keeps the timeout short enough that every one of the sixteen presence patterns can be created and torn down in a few clocks while still holding a pattern steady across a full control sweep. For each presence pattern and each of the 32 combinations of input levels, it walks the 128 meaningful control values with the unused bit toggled along the way, so every override, tie-break, fallback and polarity case is met against every level of the chosen and unchosen inputs.

// File: rtl/sss_pkg.sv
package sss_pkg;

  // Source choice for one sync axis.
  typedef enum logic {
    SRC_PRIMARY = 1'b0,  // dedicated line
    SRC_ALT     = 1'b1   // green HSYNC or separator VSYNC
  } src_e;

  // Control byte, msb first.
  typedef struct packed {
    logic spare;      // [7] unused
    logic coast_sel;  // [6] 0 pin, 1 chosen VSYNC
    logic hs_inv;     // [5] 1 inverts HSYNC
    logic hs_ovr;     // [4] force HSYNC source
    logic hs_sel;     // [3] HSYNC source / tie-break
    logic vs_keep;    // [2] 0 inverts VSYNC
    logic vs_ovr;     // [1] force VSYNC source
    logic vs_sel;     // [0] VSYNC source
  } ctrl_t;

  localparam int unsigned NUM_SYNC = 4;
  localparam int unsigned IDX_HS_DIRECT = 0;
  localparam int unsigned IDX_HS_GREEN  = 1;
  localparam int unsigned IDX_VS_DIRECT = 2;
  localparam int unsigned IDX_VS_SEP    = 3;

endpackage

// File: rtl/sss_reset_sync.sv
module sss_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sss_activity_det.sv
module sss_activity_det #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             level_o,
  output logic             seen_o
);

  logic             lvl_q, lvl_qq;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_w;
  logic             cnt_en;

  assign edge_w = lvl_q ^ lvl_qq;
  assign cnt_en = edge_w | seen_q;

  // Next state: restart the idle window on every edge, drop the flag
  // once the window has run past the limit.
  always_comb begin
    seen_d = seen_q;
    cnt_d  = cnt_q;
    if (edge_w) begin
      seen_d = 1'b1;
      cnt_d  = '0;
    end else if (seen_q) begin
      if (cnt_q >= limit_i) begin
        seen_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      lvl_qq <= 1'b0;
    end else begin
      lvl_q  <= sig_i;
      lvl_qq <= lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end

  assign level_o = lvl_q;
  assign seen_o  = seen_q;

  // R1: a sampled edge raises the flag on the next clock.
  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != lvl_qq) |=> seen_q);

  // R2: without an edge the count never runs beyond the limit while flagged.
  p_flag_needs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !edge_w && (cnt_q >= limit_i)) |=> !seen_q);

endmodule

// File: rtl/sss_source_pick.sv
module sss_source_pick
  import sss_pkg::*;
#(
  parameter bit TIE_BY_SEL = 1'b1
) (
  input  logic ovr_i,
  input  logic sel_i,
  input  logic prim_seen_i,
  input  logic alt_seen_i,
  output src_e src_o
);

  src_e tie_src;

  generate
    if (TIE_BY_SEL) begin : g_tie_sel
      assign tie_src = sel_i ? SRC_ALT : SRC_PRIMARY;
    end else begin : g_tie_prim
      assign tie_src = SRC_PRIMARY;
    end
  endgenerate

  always_comb begin
    if (ovr_i) begin
      src_o = sel_i ? SRC_ALT : SRC_PRIMARY;
    end else if (prim_seen_i && alt_seen_i) begin
      src_o = tie_src;
    end else if (alt_seen_i) begin
      src_o = SRC_ALT;
    end else begin
      src_o = SRC_PRIMARY;
    end
  end

endmodule

// File: rtl/sss_out_stage.sv
module sss_out_stage
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_t      ctrl_i,
  input  logic [1:0] hs_lvl_i,
  input  logic [1:0] vs_lvl_i,
  input  src_e       hs_src_i,
  input  src_e       vs_src_i,
  input  logic       coast_pin_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       coast_o
);

  logic hs_raw, vs_raw;
  logic hs_d, vs_d, coast_d;
  logic hs_q, vs_q, coast_q;

  always_comb begin
    hs_raw  = (hs_src_i == SRC_ALT) ? hs_lvl_i[1] : hs_lvl_i[0];
    vs_raw  = (vs_src_i == SRC_ALT) ? vs_lvl_i[1] : vs_lvl_i[0];
    hs_d    = hs_raw ^ ctrl_i.hs_inv;
    vs_d    = vs_raw ^ ~ctrl_i.vs_keep;
    coast_d = ctrl_i.coast_sel ? vs_raw : coast_pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      coast_q <= 1'b0;
    end else begin
      hs_q    <= hs_d;
      vs_q    <= vs_d;
      coast_q <= coast_d;
    end
  end

  assign hsync_o = hs_q;
  assign vsync_o = vs_q;
  assign coast_o = coast_q;

  // R3/R5: forced HSYNC source and polarity seen at the register output.
  p_hs_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.hs_ovr |=> (hsync_o == (($past(ctrl_i.hs_sel) ? $past(hs_lvl_i[1])
                                     : $past(hs_lvl_i[0])) ^ $past(ctrl_i.hs_inv))));

  // R6/R8: forced VSYNC source and polarity.
  p_vs_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.vs_ovr |=> (vsync_o == (($past(ctrl_i.vs_sel) ? $past(vs_lvl_i[1])
                                     : $past(vs_lvl_i[0])) ^ !$past(ctrl_i.vs_keep))));

  // R9: coast from the pin when the pin is selected.
  p_coast_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.coast_sel |=> (coast_o == $past(coast_pin_i)));

endmodule

// File: rtl/sync_source_select.sv
module sync_source_select
  import sss_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_direct_i,
  input  logic             hs_green_i,
  input  logic             vs_direct_i,
  input  logic             vs_sep_i,
  input  logic             coast_pin_i,
  input  logic [7:0]       ctrl_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             coast_o,
  output logic [3:0]       present_o
);

  logic                rst_sync_n;
  logic [NUM_SYNC-1:0] raw_in;
  logic [NUM_SYNC-1:0] lvl;
  logic [NUM_SYNC-1:0] seen;
  ctrl_t               ctrl;
  src_e                hs_src, vs_src;

  assign ctrl   = ctrl_t'(ctrl_i);
  assign raw_in = {vs_sep_i, vs_direct_i, hs_green_i, hs_direct_i};

  sss_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_det
      sss_activity_det #(.CNT_W(CNT_W)) u_det (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .sig_i   (raw_in[i]),
        .limit_i (idle_limit_i),
        .level_o (lvl[i]),
        .seen_o  (seen[i])
      );
    end
  endgenerate

  sss_source_pick #(.TIE_BY_SEL(1'b1)) u_hs_pick (
    .ovr_i       (ctrl.hs_ovr),
    .sel_i       (ctrl.hs_sel),
    .prim_seen_i (seen[IDX_HS_DIRECT]),
    .alt_seen_i  (seen[IDX_HS_GREEN]),
    .src_o       (hs_src)
  );

  sss_source_pick #(.TIE_BY_SEL(1'b0)) u_vs_pick (
    .ovr_i       (ctrl.vs_ovr),
    .sel_i       (ctrl.vs_sel),
    .prim_seen_i (seen[IDX_VS_DIRECT]),
    .alt_seen_i  (seen[IDX_VS_SEP]),
    .src_o       (vs_src)
  );

  sss_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctrl_i      (ctrl),
    .hs_lvl_i    (lvl[IDX_HS_GREEN:IDX_HS_DIRECT]),
    .vs_lvl_i    (lvl[IDX_VS_SEP:IDX_VS_DIRECT]),
    .hs_src_i    (hs_src),
    .vs_src_i    (vs_src),
    .coast_pin_i (coast_pin_i),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .coast_o     (coast_o)
  );

  assign present_o = seen;

  // R4: lone present direct HSYNC is followed when not forced.
  p_hs_single_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_i[4] && seen[IDX_HS_DIRECT] && !seen[IDX_HS_GREEN])
      |=> (hsync_o == ($past(lvl[IDX_HS_DIRECT]) ^ $past(ctrl_i[5]))));

  // R7: lone present separator VSYNC is followed when not forced.
  p_vs_sep_only_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_i[1] && !seen[IDX_VS_DIRECT] && seen[IDX_VS_SEP])
      |=> (vsync_o == ($past(lvl[IDX_VS_SEP]) ^ !$past(ctrl_i[2]))));

endmodule

// File: tb/sync_source_select_tb.sv
module sync_source_select_tb_top;

  localparam int unsigned CW = 8;

  logic          clk;
  logic          rst_n;
  logic          hs_a, hs_g, vs_a, vs_s, cpin;
  logic [7:0]    ctrl;
  logic [CW-1:0] limit;
  logic          hs_o, vs_o, co_o;
  logic [3:0]    pres;

  int n_chk;
  int n_err;
  bit done;

  sync_source_select #(.CNT_W(CW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_direct_i  (hs_a),
    .hs_green_i   (hs_g),
    .vs_direct_i  (vs_a),
    .vs_sep_i     (vs_s),
    .coast_pin_i  (cpin),
    .ctrl_i       (ctrl),
    .idle_limit_i (limit),
    .hsync_o      (hs_o),
    .vsync_o      (vs_o),
    .coast_o      (co_o),
    .present_o    (pres)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    {hs_a, hs_g, vs_a, vs_s, cpin} = '0;
    ctrl  = '0;
    limit = 4;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 reset outputs", {1'b0, hs_o, vs_o, co_o}, 4'h0);
    check("R10 reset present", pres, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // defaults: active-high HSYNC, inverted VSYNC, coast from pin (R5, R8, R9)
    check("R8 default invert", {1'b0, hs_o, vs_o, co_o}, 4'b0010);

    for (int lev = 0; lev < 32; lev++) begin
      for (int det = 0; det < 16; det++) begin
        limit = 4;
        ctrl  = '0;
        {cpin, vs_s, vs_a, hs_g, hs_a} = lev[4:0];
        repeat (12) @(negedge clk);
        check("R2 flags expire", pres, 4'h0);
        limit = 8'd255;
        for (int t = 0; t < 2; t++) begin
          {vs_s, vs_a, hs_g, hs_a} = {vs_s, vs_a, hs_g, hs_a} ^ det[3:0];
          @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check("R1 flags set", pres, det[3:0]);
        for (int c = 0; c < 128; c++) begin
          logic [7:0] cv;
          logic h_alt, v_alt, v_raw, h_exp, v_exp, c_exp;
          // R11: spare bit driven with both values across the sweep
          cv = {c[0] ^ c[3], c[6:0]};
          ctrl = cv;
          h_alt = cv[4] ? cv[3] : ((det[0] && det[1]) ? cv[3] : (det[1] && !det[0]));
          v_alt = cv[1] ? cv[0] : (!det[2] && det[3]);
          h_exp = (h_alt ? lev[1] : lev[0]) ^ cv[5];
          v_raw = v_alt ? lev[3] : lev[2];
          v_exp = v_raw ^ !cv[2];
          c_exp = cv[6] ? v_raw : lev[4];
          @(negedge clk);
          if (cv[4]) check("R3+R5+R10+R11 hsync", {3'b0, hs_o}, {3'b0, h_exp});
          else       check("R4+R5+R10+R11 hsync", {3'b0, hs_o}, {3'b0, h_exp});
          if (cv[1]) check("R6+R8+R11 vsync", {3'b0, vs_o}, {3'b0, v_exp});
          else       check("R7+R8+R11 vsync", {3'b0, vs_o}, {3'b0, v_exp});
          check("R9+R11 coast", {3'b0, co_o}, {3'b0, c_exp});
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule